// File: doc/BRIEF.md
# Adaptive Gain Equalizer Subband Kernel

This block boosts one subband of a speech signal when its level rises quickly above the background. Each accepted sample is rectified. Its magnitude then drives two first-order recursive averages. The fast average follows the envelope of the subband. The slow average estimates the noise floor, and it is never allowed to exceed the fast average. The ratio of the two averages is the gain, so a steady background gives a gain of one and a burst of speech gives more.

The ratio is formed without a divider. The floor is normalised, and its leading bits index a table of reciprocals that is computed at elaboration. The quotient is then clipped to a programmable ceiling and held at unity from below. The original signed sample is multiplied by this gain and saturated back to the input width. One kernel serves one band. A filter bank in front of it and an adder behind it are outside the block.

The smoothing coefficients are unsigned Q0.16 values. A coefficient for time constant T at sample rate Fs is 1/(Fs·T). Typical settings are 30 ms for the fast average, 3 s for the floor, and a ceiling of about 3.16 (10 dB), which is 25905 in Q3.13.

Top module: `agek_kernel`

## Requirements
- R1: While reset is held and after it is released, out_valid is 0, out_sample is 0, out_gain is 8192 (1.0 in Q3.13), and both averages are zero.
- R2: A sample taken with in_valid high at a clock edge produces out_valid high after that edge, with out_sample and out_gain updated at the same edge; out_valid is low after any edge where in_valid was low.
- R3: With in_valid low, in_sample and the register inputs have no effect: out_sample, out_gain and both averages keep their values.
- R4: Only the magnitude of in_sample enters the averages (two's complement, -32768 giving 32768), so mirrored inputs give equal gains; the sign of out_sample follows the sign of in_sample.
- R5: The fast average updates as floor(((65536-a)·A + a·|x| + 32768) / 65536), with a = coef_fast.
- R6: The floor candidate uses the same form with coef_slow on the previous floor; the stored floor is the smaller of that candidate and the new fast average, so the floor never exceeds the fast average.
- R7: The quotient is computed from the new averages: with e the leading-one position of the floor and m its top 7 bits taken from the leading one downward (zero-filled below bit 0), r = floor(2^22 / m) and q = floor(A·r / 2^(e+3)).
- R8: A floor of zero is treated as a floor of one.
- R9: out_gain is q clipped to gain_limit and then raised to at least 8192, so a limit under 8192 gives a gain of exactly 8192.
- R10: out_sample is floor((x·g + 4096) / 8192), saturated to the range -32768 to 32767.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Marks a subband sample on in_sample |
| in_sample | input | DW | Signed subband sample |
| coef_fast | input | CW | Fast average coefficient, unsigned Q0.16 |
| coef_slow | input | CW | Floor coefficient, unsigned Q0.16 |
| gain_limit | input | GW | Gain ceiling, unsigned Q3.13 |
| out_valid | output | 1 | Marks a new result, one cycle after in_valid |
| out_sample | output | DW | Signed gain-weighted sample, saturated |
| out_gain | output | GW | Gain applied to the sample, unsigned Q3.13 |

## Verification
The hardest case to reach from the ports is the floor clamp. Its effect is hidden at the moment it acts, because the lower gain clamp hides a floor that is too high. It shows only later, once the fast average climbs again over a floor that should have stayed low. The bench sets the averages exactly using the coefficient extremes 0 and 65535. It forces the slow candidate above the fast average, then raises the fast average and checks the hand-computed gain of two. A zero floor is reached directly out of reset with a slow coefficient of zero.

// File: rtl/agek_pkg.sv
package agek_pkg;

  localparam int unsigned DEF_DW = 16;
  localparam int unsigned DEF_CW = 16;
  localparam int unsigned DEF_GW = 16;
  localparam int unsigned DEF_GF = 13;
  localparam int unsigned DEF_LB = 6;
  localparam int unsigned DEF_RB = 16;

  // Reciprocal of the normalised mantissa (2^lb + idx), scaled by 2^(lb+rb).
  function automatic logic [31:0] recip_entry(input int unsigned lb,
                                              input int unsigned rb,
                                              input int unsigned idx);
    logic [63:0] num;
    logic [63:0] den;
    num = 64'd1 << (lb + rb);
    den = (64'd1 << lb) + 64'(idx);
    return 32'(num / den);
  endfunction

endpackage

// File: rtl/agek_ema.sv
module agek_ema #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic [AW-1:0] state_i,
  input  logic [AW-1:0] mag_i,
  input  logic [CW-1:0] coef_i,
  output logic [AW-1:0] next_o
);

  localparam int PW = AW + CW + 2;

  function automatic logic [AW-1:0] blend(input logic [AW-1:0] prev,
                                          input logic [AW-1:0] mag,
                                          input logic [CW-1:0] coef);
    logic [CW:0]   keep_w;
    logic [PW-1:0] keep_p;
    logic [PW-1:0] take_p;
    logic [PW-1:0] sum_p;
    keep_w = {1'b1, {CW{1'b0}}} - {1'b0, coef};
    keep_p = PW'(prev) * PW'(keep_w);
    take_p = PW'(mag) * PW'(coef);
    sum_p  = keep_p + take_p + (PW'(1) << (CW - 1));
    return AW'(sum_p >> CW);
  endfunction

  assign next_o = blend(state_i, mag_i, coef_i);

endmodule

// File: rtl/agek_recip.sv
module agek_recip #(
  parameter int AW = 16,
  parameter int GW = 16,
  parameter int GF = 13,
  parameter int LB = 6,
  parameter int RB = 16
) (
  input  logic [AW-1:0] sta_i,
  input  logic [AW-1:0] nfl_i,
  input  logic [GW-1:0] limit_i,
  output logic [GW-1:0] gain_o
);

  localparam int EW   = $clog2(AW);
  localparam int MW   = LB + 1;
  localparam int RWID = RB + 1;
  localparam int NENT = 2 ** LB;
  localparam int PRW  = AW + RWID;
  localparam int SH   = RB - GF;

  logic [RWID-1:0] lut [NENT];

  for (genvar gi = 0; gi < NENT; gi++) begin : g_lut
    assign lut[gi] = RWID'(agek_pkg::recip_entry(LB, RB, gi));
  end

  logic [AW-1:0]   nfl_eff;
  logic [EW-1:0]   lead;
  logic [MW-1:0]   mant;
  logic [LB-1:0]   idx;
  logic [RWID-1:0] recip;
  logic [PRW-1:0]  prod;
  logic [PRW-1:0]  quot;
  logic [PRW-1:0]  lim_ext;
  logic [PRW-1:0]  one_ext;
  logic [PRW-1:0]  clipped;
  logic [PRW-1:0]  floored;

  always_comb begin
    nfl_eff = (nfl_i == '0) ? AW'(1) : nfl_i;
    lead    = '0;
    for (int i = 0; i < AW; i++) begin
      if (nfl_eff[i]) lead = EW'(i);
    end
  end

  always_comb begin
    if (int'(lead) >= LB) mant = MW'(nfl_eff >> (int'(lead) - LB));
    else                  mant = MW'(nfl_eff << (LB - int'(lead)));
  end

  assign idx   = LB'(mant);
  assign recip = lut[idx];

  always_comb begin
    prod    = PRW'(sta_i) * PRW'(recip);
    quot    = prod >> (int'(lead) + SH);
    lim_ext = PRW'(limit_i);
    one_ext = PRW'(1) << GF;
    clipped = (quot > lim_ext) ? lim_ext : quot;
    floored = (clipped < one_ext) ? one_ext : clipped;
  end

  assign gain_o = GW'(floored);

endmodule

// File: rtl/agek_scale.sv
module agek_scale #(
  parameter int DW = 16,
  parameter int GW = 16,
  parameter int GF = 13
) (
  input  logic signed [DW-1:0] x_i,
  input  logic        [GW-1:0] g_i,
  output logic signed [DW-1:0] y_o
);

  localparam int PW = DW + GW + 2;
  localparam logic signed [PW-1:0] HALF = PW'(1) << (GF - 1);
  localparam logic signed [PW-1:0] MAXV = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW-1:0] MINV = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  function automatic logic signed [DW-1:0] weigh(input logic signed [DW-1:0] x,
                                                 input logic [GW-1:0] g);
    logic signed [PW-1:0] xs;
    logic signed [PW-1:0] gs;
    logic signed [PW-1:0] acc;
    logic signed [PW-1:0] sh;
    xs  = PW'(x);
    gs  = $signed(PW'(g));
    acc = xs * gs + HALF;
    sh  = acc >>> GF;
    if (sh > MAXV)      return DW'(MAXV);
    else if (sh < MINV) return DW'(MINV);
    else                return DW'(sh);
  endfunction

  assign y_o = weigh(x_i, g_i);

endmodule

// File: rtl/agek_kernel.sv
module agek_kernel #(
  parameter int DW = agek_pkg::DEF_DW,
  parameter int CW = agek_pkg::DEF_CW,
  parameter int GW = agek_pkg::DEF_GW,
  parameter int GF = agek_pkg::DEF_GF,
  parameter int LB = agek_pkg::DEF_LB,
  parameter int RB = agek_pkg::DEF_RB
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_sample,
  input  logic        [CW-1:0] coef_fast,
  input  logic        [CW-1:0] coef_slow,
  input  logic        [GW-1:0] gain_limit,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_sample,
  output logic        [GW-1:0] out_gain
);

  localparam int AW = DW;
  localparam logic [GW-1:0] UNITY = GW'(1) << GF;

  logic [AW-1:0]        mag;
  logic [AW-1:0]        sta_q;
  logic [AW-1:0]        nfl_q;
  logic [AW-1:0]        sta_nx;
  logic [AW-1:0]        nfl_proto;
  logic [AW-1:0]        nfl_nx;
  logic [GW-1:0]        gain_nx;
  logic signed [DW-1:0] y_nx;

  assign mag    = in_sample[DW-1] ? $unsigned(-in_sample) : $unsigned(in_sample);
  assign nfl_nx = (nfl_proto < sta_nx) ? nfl_proto : sta_nx;

  agek_ema #(.AW(AW), .CW(CW)) u_fast (
    .state_i(sta_q), .mag_i(mag), .coef_i(coef_fast), .next_o(sta_nx)
  );

  agek_ema #(.AW(AW), .CW(CW)) u_slow (
    .state_i(nfl_q), .mag_i(mag), .coef_i(coef_slow), .next_o(nfl_proto)
  );

  agek_recip #(.AW(AW), .GW(GW), .GF(GF), .LB(LB), .RB(RB)) u_recip (
    .sta_i(sta_nx), .nfl_i(nfl_nx), .limit_i(gain_limit), .gain_o(gain_nx)
  );

  agek_scale #(.DW(DW), .GW(GW), .GF(GF)) u_scale (
    .x_i(in_sample), .g_i(gain_nx), .y_o(y_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sta_q      <= '0;
      nfl_q      <= '0;
      out_valid  <= 1'b0;
      out_sample <= '0;
      out_gain   <= UNITY;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        sta_q      <= sta_nx;
        nfl_q      <= nfl_nx;
        out_sample <= y_nx;
        out_gain   <= gain_nx;
      end
    end
  end

endmodule

// File: rtl/agek_kernel_chk.sv
module agek_kernel_chk #(
  parameter int DW = 16,
  parameter int GW = 16,
  parameter int GF = 13
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic signed [DW-1:0] in_sample,
  input logic        [GW-1:0] gain_limit,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_sample,
  input logic        [GW-1:0] out_gain,
  input logic        [DW-1:0] sta_q,
  input logic        [DW-1:0] nfl_q
);

  localparam logic [GW-1:0] UNITY = GW'(1) << GF;

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && out_sample == '0 && out_gain == UNITY)); // R1

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2

  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_sample) && $stable(out_gain) && $stable(sta_q) && $stable(nfl_q))); // R3

  AST_SIGN_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_sample[DW-1]) |=> !out_sample[DW-1]); // R4

  AST_SIGN_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sample[DW-1]) |=> out_sample[DW-1]); // R4

  AST_FLOOR_UNDER_AVG: assert property (@(posedge clk) disable iff (!rst_n)
    nfl_q <= sta_q); // R6

  AST_GAIN_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_gain >= UNITY && (out_gain <= $past(gain_limit) || out_gain == UNITY))); // R9

endmodule

bind agek_kernel agek_kernel_chk #(.DW(DW), .GW(GW), .GF(GF)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
  .gain_limit(gain_limit), .out_valid(out_valid), .out_sample(out_sample),
  .out_gain(out_gain), .sta_q(sta_q), .nfl_q(nfl_q)
);

// File: tb/agek_kernel_tb_top.sv
module agek_kernel_tb_top;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic signed [15:0] in_sample = '0;
  logic        [15:0] coef_fast = '0;
  logic        [15:0] coef_slow = '0;
  logic        [15:0] gain_limit = '0;
  logic               out_valid;
  logic signed [15:0] out_sample;
  logic        [15:0] out_gain;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  longint m_sta, m_nfl, exp_gain, exp_out;

  always #4 clk = ~clk;

  agek_kernel dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .coef_fast(coef_fast), .coef_slow(coef_slow), .gain_limit(gain_limit),
    .out_valid(out_valid), .out_sample(out_sample), .out_gain(out_gain)
  );

  // stimulus: {sample, fast coef, slow coef, limit}
  localparam logic [63:0] VEC [10] = '{
    {16'd1200,  16'd4000,  16'd30,    16'd25905},
    {16'hF448,  16'd4000,  16'd30,    16'd25905},
    {16'd9000,  16'd20000, 16'd300,   16'd25905},
    {16'hB1E0,  16'd20000, 16'd300,   16'd40000},
    {16'd50,    16'd1000,  16'd5000,  16'd25905},
    {16'hFF6A,  16'd65535, 16'd2,     16'd25905},
    {16'd30000, 16'd8000,  16'd8000,  16'd65535},
    {16'd7,     16'd1,     16'd1,     16'd12000},
    {16'd16000, 16'd60000, 16'd100,   16'd25905},
    {16'd0,     16'd2048,  16'd64,    16'd25905}
  };

  function automatic longint ref_avg(longint s, longint x, longint c);
    return (s * 65536 + c * (x - s) + 32768) / 65536;
  endfunction

  function automatic longint ref_gain(longint a, longint n, longint lim);
    longint v, e, m, r, q;
    v = (n == 0) ? 1 : n;
    e = 0;
    while ((v >> (e + 1)) != 0) e++;
    m = (e >= 6) ? (v >> (e - 6)) : (v << (6 - e));
    r = (longint'(1) << 22) / m;
    q = (a * r) >> (e + 3);
    if (q > lim) q = lim;
    if (q < 8192) q = 8192;
    return q;
  endfunction

  function automatic longint ref_out(longint x, longint g);
    longint v, q;
    v = x * g + 4096;
    if (v >= 0) q = v / 8192;
    else        q = -((-v + 8191) / 8192);
    if (q > 32767)  q = 32767;
    if (q < -32768) q = -32768;
    return q;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; in_sample = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_sta = 0; m_nfl = 0;
  endtask

  task automatic put(input logic [15:0] x, input logic [15:0] a, input logic [15:0] b,
                     input logic [15:0] lim);
    longint xv, mg, pr;
    @(negedge clk);
    in_sample = $signed(x); coef_fast = a; coef_slow = b; gain_limit = lim; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    xv = longint'($signed(x));
    mg = (xv < 0) ? -xv : xv;
    m_sta = ref_avg(m_sta, mg, longint'(a));
    pr    = ref_avg(m_nfl, mg, longint'(b));
    m_nfl = (pr < m_sta) ? pr : m_sta;
    exp_gain = ref_gain(m_sta, m_nfl, longint'(lim));
    exp_out  = ref_out(xv, exp_gain);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    m_sta = 0; m_nfl = 0;
    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1", "out_valid in reset", longint'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "out_valid", longint'(out_valid), 0);
    chk("R1", "out_sample", longint'(out_sample), 0);
    chk("R1", "out_gain", longint'(out_gain), 8192);

    // R8 R9: zero floor from reset, gain clipped to limit
    put(16'd100, 16'd32768, 16'd0, 16'd25905);
    chk("R2", "out_valid after sample", longint'(out_valid), 1);
    chk("R8", "gain on zero floor", longint'(out_gain), 25905);
    chk("R10", "weighted sample", longint'(out_sample), 316);

    // R3: idle inputs ignored
    @(negedge clk);
    in_sample = 16'sd5000; coef_fast = 16'd65535; coef_slow = 16'd65535; gain_limit = 16'd9000;
    repeat (3) @(negedge clk);
    chk("R2", "out_valid idle", longint'(out_valid), 0);
    chk("R3", "sample held", longint'(out_sample), 316);
    chk("R3", "gain held", longint'(out_gain), 25905);
    put(16'd100, 16'd32768, 16'd0, 16'd25905);
    chk("R3", "state untouched gain", longint'(out_gain), exp_gain);
    chk("R3", "state untouched out", longint'(out_sample), exp_out);

    // R5 R7: exact averages then ratio of two
    do_reset();
    put(16'd1000, 16'd65535, 16'd65535, 16'd65535);
    chk("R9", "equal averages floor to unity", longint'(out_gain), 8192);
    chk("R10", "unity passes sample", longint'(out_sample), 1000);
    put(16'd5000, 16'd16384, 16'd0, 16'd65535);
    chk("R5", "gain from fast avg 2000", longint'(out_gain), 16383);
    chk("R7", "weighted by ratio", longint'(out_sample), 9999);

    // R6: floor candidate above fast average is clamped
    put(16'd30000, 16'd0, 16'd65535, 16'd65535);
    chk("R6", "clamped floor unity", longint'(out_gain), 8192);
    put(16'd6000, 16'd32768, 16'd0, 16'd65535);
    chk("R6", "floor kept at avg", longint'(out_gain), 16383);
    chk("R6", "output with floor kept", longint'(out_sample), 11999);

    // R4: mirrored input
    do_reset();
    put(16'd1000, 16'd65535, 16'd65535, 16'd65535);
    put(16'hEC78, 16'd16384, 16'd0, 16'd65535);
    chk("R4", "negative gain same", longint'(out_gain), 16383);
    chk("R4", "negative output", longint'(out_sample), -9999);

    // R9: limit below unity
    do_reset();
    put(16'd1234, 16'd32768, 16'd0, 16'd4096);
    chk("R9", "low limit gives unity", longint'(out_gain), 8192);
    chk("R9", "low limit passes sample", longint'(out_sample), 1234);

    // R10: saturation both signs
    do_reset();
    put(16'd32767, 16'd32768, 16'd0, 16'd65535);
    chk("R10", "positive saturation", longint'(out_sample), 32767);
    put(16'h8000, 16'd32768, 16'd0, 16'd65535);
    chk("R10", "negative saturation", longint'(out_sample), -32768);
    chk("R4", "full-scale negative gain", longint'(out_gain), 65535);

    // table walk, R7 R5 R6 against restated model
    do_reset();
    for (int i = 0; i < 10; i++) begin
      put(VEC[i][63:48], VEC[i][47:32], VEC[i][31:16], VEC[i][15:0]);
      chk("R7", $sformatf("vec %0d gain", i), longint'(out_gain), exp_gain);
      chk("R10", $sformatf("vec %0d out", i), longint'(out_sample), exp_out);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule